// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block takes a small CPU core out of normal execution and into an interrupt handler. It watches for an accepted request at safe points. A safe point is the end of an ordinary instruction, or an iteration boundary inside a long repeat or string operation, which is suspended there rather than run to completion. The sequencer starts on the cycle after the safe point. It runs a fixed series of steps:

- It reads an acknowledge word at address zero into a private temporary word.
- It pulses a clear for the acknowledged source.
- It pushes the flag word as it stood at the start.
- It clears the enable, debug and stack-select flags.
- It pushes the temporary word and the return address.
- It loads the priority level.
- It redirects fetch to the handler.

A software interrupt instruction skips the acknowledge read and supplies its number directly. Priority among sources is resolved outside the block. `irq_pending` arrives already qualified by that arbitration.

Two ports use valid/ready handshakes: the acknowledge read request and the stack write port. On each, the block raises valid and holds it, together with its address and data, until it sees ready on a clock edge. The consumer may hold ready low for any number of cycles to apply back-pressure. The acknowledge response needs no ready. The block waits for `rd_resp_valid` and takes the data in that cycle. All other pins are plain one-cycle strobes or levels.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware entry starts only when `irq_pending` is high, flag bit 6 (interrupt enable) of `flg_in` is high, and `insn_done` is high. `busy` rises on the next cycle. With the enable bit low, or with no boundary, `busy` stays low.
- R2: While `rpt_active` is high, `rpt_iter_done` also counts as a boundary. `rpt_iter_done` with `rpt_active` low starts nothing.
- R3: A hardware entry makes exactly one acknowledge read request, at address 0. `rd_req_valid` stays high until `rd_req_ready` is seen.
- R4: One cycle after the response is taken, `clr_req` pulses once, with `clr_num` equal to bits 5:0 of the response word. This happens before any stack write.
- R5: Four stack words are written, in this order and at these addresses:
  - the flag word sampled at the start, at SP-2;
  - the temporary word, at SP-4;
  - PC bits 19:16, zero-extended, at SP-6;
  - PC bits 15:0, at SP-8.
  
  Each write holds `st_valid`, `st_addr` and `st_data` stable until `st_ready`.
- R6: Between the first and second stack writes, one flag write gives the saved word with bits 6 (enable), 5 (debug) and 7 (stack select) cleared. For a software interrupt numbered 32 to 63, bit 7 is left as saved.
- R7: After the last stack write, a second flag write loads bits 14:12 (priority level). For a hardware entry it loads the level from bits 10:8 of the acknowledge word. For a software entry it keeps the saved level.
- R8: One cycle after that write, `redirect_valid` pulses for one cycle with `redirect_addr` = `vec_base` + 4 × number. In the same cycle `sp_wr_en` is high with `sp_wr_data` = SP-8.
- R9: A software entry is taken when `swi_valid` is high with `insn_done`, regardless of the enable flag. It makes no acknowledge read and no clear. Its temporary word holds `swi_num` in bits 5:0 and the current level in bits 10:8. It wins over a hardware request at the same boundary.
- R10: `busy` is high from the cycle after the start through the redirect cycle and low on the next cycle. Requests and boundaries seen while `busy` is high start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Ordinary instruction completes this cycle |
| rpt_active | input | 1 | A repeat/string instruction is executing |
| rpt_iter_done | input | 1 | Iteration boundary of the repeat instruction |
| irq_pending | input | 1 | Arbitrated hardware request is pending |
| swi_valid | input | 1 | Completing instruction is a software interrupt |
| swi_num | input | NUM_W | Software interrupt number |
| flg_in | input | DW | Current flag word |
| sp_in | input | SP_W | Current stack pointer |
| pc_in | input | PC_W | Return address |
| vec_base | input | PC_W | Handler table base |
| rd_req_valid | output | 1 | Acknowledge read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | PC_W | Acknowledge read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_data | input | DW | Acknowledge word |
| clr_req | output | 1 | Clear strobe for the acknowledged source |
| clr_num | output | NUM_W | Number of the source to clear |
| st_valid | output | 1 | Stack write valid |
| st_ready | input | 1 | Stack write accepted |
| st_addr | output | SP_W | Stack write address |
| st_data | output | DW | Stack write data |
| flg_wr_en | output | 1 | Flag word write strobe |
| flg_wr_data | output | DW | New flag word |
| sp_wr_en | output | 1 | Stack pointer write strobe |
| sp_wr_data | output | SP_W | New stack pointer |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_addr | output | PC_W | Handler start address |
| busy | output | 1 | Entry sequence in progress |

## Verification
The assertions assume three things about the inputs. `rd_resp_valid` arrives only after an accepted acknowledge request and pulses once per request. `insn_done` and `rpt_iter_done` describe the core faithfully. The core does not change `sp_in` or `pc_in` meaning while `busy` is high, because those values are captured at the start. The bench acts as the memory and returns exactly one response on the cycle after each accepted request. It drives boundaries only as the core would. It applies back-pressure on both handshakes with cyclic ready patterns, so the hold-while-stalled properties are exercised. In some runs it keeps requests and boundaries asserted during the sequence, to show that they are held off.

// File: rtl/irqe_pkg.sv
package irqe_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ACK_REQ,
    S_ACK_WAIT,
    S_ACK_CLR,
    S_PUSH_FLG,
    S_FLAGS,
    S_PUSH_TMP,
    S_PUSH_PCH,
    S_PUSH_PCL,
    S_SET_IPL,
    S_REDIR
  } irqe_state_e;

  typedef enum logic [1:0] {W_FLG, W_TMP, W_PCH, W_PCL} push_sel_e;

  localparam int FLG_D       = 5;
  localparam int FLG_I       = 6;
  localparam int FLG_U       = 7;
  localparam int LVL_W       = 3;
  localparam int IPL_LSB     = 12;
  localparam int TMP_LVL_LSB = 8;
endpackage

// File: rtl/irqe_trigger.sv
module irqe_trigger (
  input  logic idle,
  input  logic insn_done,
  input  logic rpt_active,
  input  logic rpt_iter_done,
  input  logic irq_pending,
  input  logic ien_flag,
  input  logic swi_valid,
  output logic take_sw,
  output logic take_hw
);
  logic boundary;

  // A repeat instruction may be cut short at any iteration edge.
  assign boundary = insn_done | (rpt_active & rpt_iter_done);
  assign take_sw  = idle & swi_valid & insn_done;
  assign take_hw  = idle & ~take_sw & irq_pending & ien_flag & boundary;
endmodule

// File: rtl/irqe_stack.sv
module irqe_stack
  import irqe_pkg::*;
#(
  parameter int DW   = 16,
  parameter int SP_W = 16,
  parameter int PC_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SP_W-1:0] sp_init,
  input  logic [PC_W-1:0] pc_init,
  input  logic            fire,
  input  push_sel_e       sel,
  input  logic [DW-1:0]   flg_word,
  input  logic [DW-1:0]   tmp_word,
  output logic [SP_W-1:0] push_addr,
  output logic [DW-1:0]   push_data,
  output logic [SP_W-1:0] sp_cur
);
  localparam int HI_W = (PC_W > DW) ? PC_W - DW : 1;
  localparam logic [SP_W-1:0] STEP = SP_W'(2);

  logic [SP_W-1:0] sp_q;
  logic [PC_W-1:0] pc_q;
  logic [DW-1:0]   pc_hi, pc_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
      pc_q <= '0;
    end else if (load) begin
      sp_q <= sp_init;
      pc_q <= pc_init;
    end else if (fire) begin
      sp_q <= sp_q - STEP;
    end
  end

  // Pre-decrement: each word lands one slot below the current pointer.
  assign push_addr = sp_q - STEP;
  assign sp_cur    = sp_q;

  generate
    if (PC_W > DW) begin : g_split
      assign pc_hi = {{(DW-HI_W){1'b0}}, pc_q[PC_W-1:DW]};
      assign pc_lo = pc_q[DW-1:0];
    end else begin : g_narrow
      assign pc_hi = '0;
      assign pc_lo = DW'(pc_q);
    end
  endgenerate

  always_comb begin
    unique case (sel)
      W_FLG:   push_data = flg_word;
      W_TMP:   push_data = tmp_word;
      W_PCH:   push_data = pc_hi;
      default: push_data = pc_lo;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqe_pkg::*;
#(
  parameter int DW         = 16,
  parameter int SP_W       = 16,
  parameter int PC_W       = 20,
  parameter int NUM_W      = 6,
  parameter int SWI_KEEP_U = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic             rpt_active,
  input  logic             rpt_iter_done,
  input  logic             irq_pending,
  input  logic             swi_valid,
  input  logic [NUM_W-1:0] swi_num,
  input  logic [DW-1:0]    flg_in,
  input  logic [SP_W-1:0]  sp_in,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [PC_W-1:0]  vec_base,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [PC_W-1:0]  rd_addr,
  input  logic             rd_resp_valid,
  input  logic [DW-1:0]    rd_data,
  output logic             clr_req,
  output logic [NUM_W-1:0] clr_num,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [SP_W-1:0]  st_addr,
  output logic [DW-1:0]    st_data,
  output logic             flg_wr_en,
  output logic [DW-1:0]    flg_wr_data,
  output logic             sp_wr_en,
  output logic [SP_W-1:0]  sp_wr_data,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_addr,
  output logic             busy
);
  localparam logic [NUM_W:0] KEEP_U_THR = (NUM_W+1)'(SWI_KEEP_U);

  irqe_state_e     state_q, state_d;
  logic [DW-1:0]   flg_save_q, tmp_q, tmp_sw;
  logic            sw_q;
  logic            idle, take_sw, take_hw, start, push_fire, keep_u;
  logic [NUM_W-1:0] num_cur;
  logic [LVL_W-1:0] lvl_cur;
  logic [DW-1:0]   flg_clr, flg_ipl;
  push_sel_e       push_sel;
  logic [SP_W-1:0] sp_cur;

  assign idle  = (state_q == S_IDLE);
  assign start = take_sw | take_hw;

  irqe_trigger u_trig (
    .idle          (idle),
    .insn_done     (insn_done),
    .rpt_active    (rpt_active),
    .rpt_iter_done (rpt_iter_done),
    .irq_pending   (irq_pending),
    .ien_flag      (flg_in[FLG_I]),
    .swi_valid     (swi_valid),
    .take_sw       (take_sw),
    .take_hw       (take_hw)
  );

  // Software entry builds its temporary word locally: number and current level.
  always_comb begin
    tmp_sw = '0;
    tmp_sw[NUM_W-1:0] = swi_num;
    tmp_sw[TMP_LVL_LSB +: LVL_W] = flg_in[IPL_LSB +: LVL_W];
  end

  assign num_cur = tmp_q[NUM_W-1:0];
  assign lvl_cur = tmp_q[TMP_LVL_LSB +: LVL_W];
  assign keep_u  = sw_q && ({1'b0, num_cur} >= KEEP_U_THR);

  always_comb begin
    flg_clr = flg_save_q;
    flg_clr[FLG_I] = 1'b0;
    flg_clr[FLG_D] = 1'b0;
    if (!keep_u) flg_clr[FLG_U] = 1'b0;
    flg_ipl = flg_clr;
    if (!sw_q) flg_ipl[IPL_LSB +: LVL_W] = lvl_cur;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (take_sw) state_d = S_PUSH_FLG;
                  else if (take_hw) state_d = S_ACK_REQ;
      S_ACK_REQ:  if (rd_req_ready) state_d = S_ACK_WAIT;
      S_ACK_WAIT: if (rd_resp_valid) state_d = S_ACK_CLR;
      S_ACK_CLR:  state_d = S_PUSH_FLG;
      S_PUSH_FLG: if (st_ready) state_d = S_FLAGS;
      S_FLAGS:    state_d = S_PUSH_TMP;
      S_PUSH_TMP: if (st_ready) state_d = S_PUSH_PCH;
      S_PUSH_PCH: if (st_ready) state_d = S_PUSH_PCL;
      S_PUSH_PCL: if (st_ready) state_d = S_SET_IPL;
      S_SET_IPL:  state_d = S_REDIR;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      flg_save_q <= '0;
      tmp_q      <= '0;
      sw_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        flg_save_q <= flg_in;
        sw_q       <= take_sw;
        tmp_q      <= take_sw ? tmp_sw : '0;
      end else if (state_q == S_ACK_WAIT && rd_resp_valid) begin
        tmp_q <= rd_data;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      S_PUSH_FLG: push_sel = W_FLG;
      S_PUSH_TMP: push_sel = W_TMP;
      S_PUSH_PCH: push_sel = W_PCH;
      default:    push_sel = W_PCL;
    endcase
  end

  assign st_valid  = (state_q == S_PUSH_FLG) || (state_q == S_PUSH_TMP) ||
                     (state_q == S_PUSH_PCH) || (state_q == S_PUSH_PCL);
  assign push_fire = st_valid & st_ready;

  irqe_stack #(.DW(DW), .SP_W(SP_W), .PC_W(PC_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .sp_init   (sp_in),
    .pc_init   (pc_in),
    .fire      (push_fire),
    .sel       (push_sel),
    .flg_word  (flg_save_q),
    .tmp_word  (tmp_q),
    .push_addr (st_addr),
    .push_data (st_data),
    .sp_cur    (sp_cur)
  );

  assign busy           = !idle;
  assign rd_req_valid   = (state_q == S_ACK_REQ);
  assign rd_addr        = '0;
  assign clr_req        = (state_q == S_ACK_CLR);
  assign clr_num        = num_cur;
  assign flg_wr_en      = (state_q == S_FLAGS) || (state_q == S_SET_IPL);
  assign flg_wr_data    = (state_q == S_SET_IPL) ? flg_ipl : flg_clr;
  assign redirect_valid = (state_q == S_REDIR);
  assign redirect_addr  = vec_base + PC_W'({num_cur, 2'b00});
  assign sp_wr_en       = redirect_valid;
  assign sp_wr_data     = sp_cur;

  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_done || (rpt_active && rpt_iter_done)));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid);

  p_clr_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> $past(rd_resp_valid));

  p_push_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data));

  p_flags_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flg_wr_en |-> !flg_wr_data[FLG_I] && !flg_wr_data[FLG_D]);

  p_redir_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid && !busy);

  p_no_ack_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q && busy |-> !rd_req_valid && !clr_req);

  p_single_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !redirect_valid |=> busy);
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_done = 0, rpt_active = 0, rpt_iter_done = 0, irq_pending = 0, swi_valid = 0;
  logic [5:0] swi_num = '0;
  logic [15:0] flg_in = '0, sp_in = '0, rd_data = '0;
  logic [19:0] pc_in = '0, vec_base = '0;
  logic rd_req_ready = 0, rd_resp_valid = 0, st_ready = 0;
  logic rd_req_valid, clr_req, st_valid, flg_wr_en, sp_wr_en, redirect_valid, busy;
  logic [19:0] rd_addr, redirect_addr;
  logic [5:0] clr_num;
  logic [15:0] st_addr, st_data, flg_wr_data, sp_wr_data;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rpt_active(rpt_active),
    .rpt_iter_done(rpt_iter_done), .irq_pending(irq_pending), .swi_valid(swi_valid),
    .swi_num(swi_num), .flg_in(flg_in), .sp_in(sp_in), .pc_in(pc_in), .vec_base(vec_base),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_data(rd_data), .clr_req(clr_req), .clr_num(clr_num),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .flg_wr_en(flg_wr_en), .flg_wr_data(flg_wr_data), .sp_wr_en(sp_wr_en),
    .sp_wr_data(sp_wr_data), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle_for(input int n, input string what);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!busy && !rd_req_valid && !st_valid, what, busy, 0);
    end
  endtask

  task automatic run_entry(input bit sw, input int num, input int lvl, input int stall,
                           input bit rpt, input bit noisy);
    logic [15:0] flg, sp, tmp, exp_clr, exp_ipl, ack;
    logic [19:0] pc, vb;
    logic [15:0] pa[4], pd[4], fw[2];
    int pcyc[4], fcyc[2];
    int np = 0, nf = 0, nack = 0, nclr = 0, nred = 0, clr_at = -1, red_at = -1;
    logic [5:0] clr_n = '0;
    logic [19:0] got_addr = '0;
    logic [15:0] got_sp = '0;
    bit resp_due = 0, rdy, srdy, spw = 0;
    for (int i = 0; i < 4; i++) begin pa[i] = '0; pd[i] = '0; pcyc[i] = 0; end
    fw[0] = '0; fw[1] = '0; fcyc[0] = 0; fcyc[1] = 0;
    flg = 16'((num * 16'h0125) ^ (lvl << 12) ^ (lvl * 16'h00A1));
    if (!sw) flg = flg | 16'h0040;
    sp  = 16'(16'h4000 + num * 6 + lvl * 2);
    pc  = 20'(32'h3_0000 ^ (num << 10) ^ (lvl * 4097) ^ stall);
    vb  = 20'(32'h0_F000 + (lvl << 8));
    ack = 16'(16'h8000 | (lvl << 8) | num);
    tmp = sw ? 16'((((flg >> 12) & 7) << 8) | num) : ack;
    exp_clr = flg & ~16'h00E0;
    if (sw && num >= 32) exp_clr = exp_clr | (flg & 16'h0080);
    exp_ipl = sw ? exp_clr : ((exp_clr & ~16'h7000) | 16'(lvl << 12));

    @(negedge clk);
    flg_in = flg; sp_in = sp; pc_in = pc; vec_base = vb; swi_num = 6'(num);
    swi_valid = sw; irq_pending = !sw;
    insn_done = sw || !rpt; rpt_active = rpt; rpt_iter_done = rpt;
    rd_data = ack;
    for (int cyc = 0; cyc < 100; cyc++) begin
      @(negedge clk);
      if (cyc == 0) chk(busy == 1'b1, "R1 R10 busy on cycle after start", busy, 1);
      if (!noisy) begin insn_done = 0; swi_valid = 0; rpt_iter_done = 0; end
      flg_in = ~flg;
      rdy  = (stall == 0) || (((cyc + stall) % 3) != 0);
      srdy = (stall == 0) || (((cyc + stall + 1) % 4) != 0);
      rd_req_ready  = rdy;
      rd_resp_valid = resp_due;
      resp_due = 0;
      if (rd_req_valid && rdy) begin
        nack++;
        chk(rd_addr == 20'h0, "R3 acknowledge address", rd_addr, 0);
        resp_due = 1;
      end
      if (clr_req) begin
        nclr++; clr_at = cyc; clr_n = clr_num;
        if (!noisy) irq_pending = 0;
      end
      st_ready = srdy;
      if (st_valid && srdy) begin
        if (np < 4) begin pa[np] = st_addr; pd[np] = st_data; pcyc[np] = cyc; end
        np++;
      end
      if (flg_wr_en) begin
        if (nf < 2) begin fw[nf] = flg_wr_data; fcyc[nf] = cyc; end
        nf++;
      end
      if (redirect_valid) begin
        nred++; red_at = cyc; got_addr = redirect_addr; got_sp = sp_wr_data; spw = sp_wr_en;
        insn_done = 0; swi_valid = 0; rpt_iter_done = 0; rpt_active = 0; irq_pending = 0;
        break;
      end
    end
    @(negedge clk);
    rd_req_ready = 0; rd_resp_valid = 0; st_ready = 0;
    chk(!busy, "R10 busy low after redirect", busy, 0);
    chk(nred == 1, "R8 one redirect", nred, 1);
    chk(got_addr == 20'(vb + 20'(num * 4)), "R8 handler address", got_addr, 20'(vb + 20'(num * 4)));
    chk(spw && got_sp == 16'(sp - 16'd8), "R8 stack pointer update", got_sp, 16'(sp - 16'd8));
    if (sw) begin
      chk(nack == 0 && nclr == 0, "R9 no acknowledge for software entry", nack + nclr, 0);
    end else begin
      chk(nack == 1, "R3 single acknowledge read", nack, 1);
      chk(nclr == 1 && clr_n == 6'(num), "R4 clear number", clr_n, num);
      chk(clr_at >= 0 && clr_at < pcyc[0], "R4 clear before first push", clr_at, pcyc[0]);
    end
    chk(np == 4, "R5 four stack words", np, 4);
    for (int i = 0; i < 4; i++)
      chk(pa[i] == 16'(sp - 16'(2 * (i + 1))), $sformatf("R5 push %0d address", i), pa[i],
          16'(sp - 16'(2 * (i + 1))));
    chk(pd[0] == flg, "R5 saved flag word", pd[0], flg);
    chk(pd[1] == tmp, sw ? "R9 temporary word" : "R5 temporary word", pd[1], tmp);
    chk(pd[2] == 16'(pc >> 16), "R5 return address high", pd[2], 16'(pc >> 16));
    chk(pd[3] == pc[15:0], "R5 return address low", pd[3], pc[15:0]);
    chk(nf == 2, "R6 R7 two flag writes", nf, 2);
    chk(fw[0] == exp_clr, "R6 cleared flags", fw[0], exp_clr);
    chk(fcyc[0] > pcyc[0] && fcyc[0] < pcyc[1], "R6 flag write placement", fcyc[0], pcyc[0]);
    chk(fw[1] == exp_ipl, "R7 priority level", fw[1], exp_ipl);
    chk(fcyc[1] > pcyc[3] && fcyc[1] < red_at, "R7 level write placement", fcyc[1], pcyc[3]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req_valid && !st_valid && !redirect_valid && !flg_wr_en && !clr_req,
        "R10 reset state idle", busy, 0);

    // R1: enable flag clear blocks a hardware entry at a boundary.
    flg_in = 16'h0000; irq_pending = 1; insn_done = 1;
    idle_for(4, "R1 no entry with enable clear");
    // R1: no boundary, no entry.
    flg_in = 16'h0040; insn_done = 0;
    idle_for(4, "R1 no entry without boundary");
    // R2: iteration edge without an active repeat is not a boundary.
    rpt_active = 0; rpt_iter_done = 1;
    idle_for(4, "R2 iteration edge ignored outside repeat");
    rpt_iter_done = 0; irq_pending = 0;

    // R9: software sweep over every number; both sides of the stack-select threshold.
    for (int n = 0; n < 64; n++) run_entry(1'b1, n, 0, n % 4, 1'b0, (n % 5) == 0);

    // Hardware sweep over all levels and edge numbers, boundary kinds and stall patterns.
    for (int l = 0; l < 8; l++) begin
      for (int k = 0; k < 5; k++) begin
        int nm;
        case (k)
          0: nm = 0;
          1: nm = 1;
          2: nm = 31;
          3: nm = 32;
          default: nm = 63;
        endcase
        run_entry(1'b0, nm, l, (l + k) % 4, ((l + k) % 2) == 1, k == 2);
      end
    end

    // R9: software request wins over a hardware request at the same boundary.
    @(negedge clk);
    flg_in = 16'h0040; swi_valid = 1; swi_num = 6'd9; irq_pending = 1; insn_done = 1;
    @(negedge clk);
    swi_valid = 0; irq_pending = 0; insn_done = 0;
    rd_req_ready = 1; st_ready = 1;
    chk(busy && st_valid && !rd_req_valid, "R9 software wins same boundary", rd_req_valid, 0);
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk(!busy, "R10 returns to idle", busy, 0);
    rd_req_ready = 0; st_ready = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule